// File: doc/BRIEF.md
# Modulo-60 Rollover Tracker

This block follows a free-running real-time count that advances once per prescaled time unit. Alongside the wide count it keeps a second view of the same progress reduced modulo 60. Each increment strobe moves both counts by one step. The step is normally 1. When a positive trim is applied on that strobe, the step is the trim amount instead. Because a trimmed step can be larger than 1, the modulo-60 view may jump across its wrap point and skip values on the way.

For each of the two counts the block reports two kinds of rollover information. The first is a sticky interrupt flag. It is raised by a wrap and stays up until software writes a one to clear it. The second is a live status bit. It tells whether the value currently shown came from a wrap at the most recent increment. Software that services a rollover interrupt late can read the live bit: if the bit has already fallen, the count has moved on since the wrap it is handling.

Each count has its own small state machine that holds both bits. Its states are QUIET (no live status, no flag), FRESH (wrap seen at the latest increment, flag raised), FRESH_ACKED (wrap seen at the latest increment, flag already cleared) and STALE (the count has moved on, flag still raised). The transitions are:
- WRAP, taken from any state to FRESH.
- ADVANCE, a non-wrapping increment: FRESH goes to STALE, FRESH_ACKED goes to QUIET.
- CLEAR, a write-one with no wrap: FRESH goes to FRESH_ACKED, STALE goes to QUIET.
- ADVANCE together with CLEAR leads to QUIET.
- HOLD: every other case keeps the current state.

Top module: `mod60_tracker`

## Requirements
- R1: After reset `cnt_mod60` is 0 and always lies in 0..59. On a cycle with `inc_stb` high it becomes (old + step) mod 60.
- R2: The step is 1 when `trim_amt` is 0. Otherwise the step equals the unsigned value of `trim_amt`. The same step applies to both counts.
- R3: `cnt_full` is N_FIELDS fields of FIELD_W bits each, 48 bits by default. On an increment it becomes (old + step) mod 2^(FIELD_W*N_FIELDS), with the carry passed from each field into the next higher one.
- R4: On a cycle with `inc_stb` low, neither count changes.
- R5: An increment where old modulo-60 value + step >= 60 sets `mod60_wrap_irq` and `mod60_roll_live` at the same edge.
- R6: A high pulse on `w1c_mod60` or `w1c_full` clears the matching sticky flag at the next edge. If a wrap of that count happens in the same cycle, the flag is set instead.
- R7: An increment that does not wrap the modulo-60 count drops `mod60_roll_live`. It leaves `mod60_wrap_irq` unchanged.
- R8: The full count behaves the same way: a carry out of its top field sets `full_wrap_irq` and `full_roll_live`. A later non-wrapping increment drops only `full_roll_live`.
- R9: While `rst_n` is low, both counts, both live bits and both sticky flags are 0.
- R10: A live bit changes only on an increment. Clear writes and idle cycles leave it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_stb | input | 1 | Prescaled increment strobe |
| trim_amt | input | TRIM_W | Positive trim step for this strobe; 0 means a plain step of 1 |
| w1c_mod60 | input | 1 | Software write-one-to-clear of the modulo-60 wrap flag |
| w1c_full | input | 1 | Software write-one-to-clear of the full-count wrap flag |
| cnt_mod60 | output | $clog2(MOD) | Modulo-60 view of the count |
| cnt_full | output | FIELD_W*N_FIELDS | Full real-time count |
| mod60_roll_live | output | 1 | Current modulo-60 value came from a wrap at the latest increment |
| full_roll_live | output | 1 | Current full count came from a wrap at the latest increment |
| mod60_wrap_irq | output | 1 | Sticky modulo-60 wrap interrupt flag |
| full_wrap_irq | output | 1 | Sticky full-count wrap interrupt flag |

## Verification
On every cycle the assertions check four things. The modulo-60 value stays in range. Both counts and both live bits hold when there is no strobe. A rising live bit comes with its flag. After each increment, each live bit agrees with whether that count's value went down. Whether the counts move by the right trimmed amount, and how set and clear interact in the same cycle, can only be shown by the bench. Its reference model runs through trimmed jumps across the wrap, clears that land on a wrap, late clears, and a complete wrap of a narrowed full count.

// File: rtl/mod60_tracker_pkg.sv
package mod60_tracker_pkg;

    typedef enum logic [1:0] {
        FL_QUIET       = 2'd0,
        FL_FRESH       = 2'd1,
        FL_FRESH_ACKED = 2'd2,
        FL_STALE       = 2'd3
    } flag_state_t;

    function automatic logic state_live(input flag_state_t s);
        return (s == FL_FRESH) || (s == FL_FRESH_ACKED);
    endfunction

    function automatic logic state_sticky(input flag_state_t s);
        return (s == FL_FRESH) || (s == FL_STALE);
    endfunction

endpackage

// File: rtl/step_select.sv
module step_select #(
    parameter int TRIM_W = 3
) (
    input  logic [TRIM_W-1:0] trim_amt,
    output logic [TRIM_W-1:0] step
);
    localparam logic [TRIM_W-1:0] UNIT = TRIM_W'(1);

    always_comb begin
        if (trim_amt == '0) begin
            step = UNIT;
        end else begin
            step = trim_amt;
        end
    end
endmodule

// File: rtl/mod_counter.sv
module mod_counter #(
    parameter int MOD    = 60,
    parameter int TRIM_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic [TRIM_W-1:0]      step,
    output logic [$clog2(MOD)-1:0] value,
    output logic                   wrap
);
    localparam int VAL_W = $clog2(MOD);
    localparam int SUM_W = VAL_W + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(MOD);

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] reduced;
    logic [VAL_W-1:0] value_nxt;

    always_comb begin
        sum       = {1'b0, value} + SUM_W'(step);
        wrap      = adv && (sum >= LIMIT);
        reduced   = (sum >= LIMIT) ? (sum - LIMIT) : sum;
        value_nxt = adv ? reduced[VAL_W-1:0] : value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= value_nxt;
        end
    end
endmodule

// File: rtl/field_counter.sv
module field_counter #(
    parameter int FIELD_W  = 16,
    parameter int N_FIELDS = 3,
    parameter int TRIM_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic [TRIM_W-1:0]             step,
    output logic [FIELD_W*N_FIELDS-1:0]   value,
    output logic                          wrap
);
    localparam int ADD_W = FIELD_W + 1;

    logic [N_FIELDS-1:0][FIELD_W-1:0] field_q;
    logic [N_FIELDS-1:0][FIELD_W-1:0] field_sum;
    logic [N_FIELDS:0]                carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        logic [ADD_W-1:0] addend;
        logic [ADD_W-1:0] total;
        if (i == 0) begin : g_low
            assign addend = ADD_W'(step);
        end else begin : g_high
            assign addend = ADD_W'(carry[i]);
        end
        assign total          = {1'b0, field_q[i]} + addend;
        assign field_sum[i]   = total[FIELD_W-1:0];
        assign carry[i+1]     = total[FIELD_W];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                field_q[i] <= '0;
            end else if (adv) begin
                field_q[i] <= field_sum[i];
            end
        end
    end

    assign value = field_q;
    assign wrap  = adv && carry[N_FIELDS];
endmodule

// File: rtl/roll_flag_fsm.sv
module roll_flag_fsm
    import mod60_tracker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic wrap,
    input  logic clr,
    output logic live,
    output logic sticky
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wrap) begin
            state_d = FL_FRESH;
        end else begin
            unique case (state_q)
                FL_QUIET: begin
                    state_d = FL_QUIET;
                end
                FL_FRESH: begin
                    if (adv && clr) begin
                        state_d = FL_QUIET;
                    end else if (adv) begin
                        state_d = FL_STALE;
                    end else if (clr) begin
                        state_d = FL_FRESH_ACKED;
                    end
                end
                FL_FRESH_ACKED: begin
                    if (adv) begin
                        state_d = FL_QUIET;
                    end
                end
                FL_STALE: begin
                    if (clr) begin
                        state_d = FL_QUIET;
                    end
                end
                default: state_d = FL_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        live   = state_live(state_q);
        sticky = state_sticky(state_q);
    end
endmodule

// File: rtl/mod60_tracker.sv
module mod60_tracker #(
    parameter int MOD      = 60,
    parameter int TRIM_W   = 3,
    parameter int FIELD_W  = 16,
    parameter int N_FIELDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc_stb,
    input  logic [TRIM_W-1:0]           trim_amt,
    input  logic                        w1c_mod60,
    input  logic                        w1c_full,
    output logic [$clog2(MOD)-1:0]      cnt_mod60,
    output logic [FIELD_W*N_FIELDS-1:0] cnt_full,
    output logic                        mod60_roll_live,
    output logic                        full_roll_live,
    output logic                        mod60_wrap_irq,
    output logic                        full_wrap_irq
);
    logic [TRIM_W-1:0] step;
    logic              mod_wrap;
    logic              full_wrap;

    step_select #(.TRIM_W(TRIM_W)) u_step (
        .trim_amt (trim_amt),
        .step     (step)
    );

    mod_counter #(.MOD(MOD), .TRIM_W(TRIM_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (inc_stb),
        .step  (step),
        .value (cnt_mod60),
        .wrap  (mod_wrap)
    );

    field_counter #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS), .TRIM_W(TRIM_W)) u_full (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (inc_stb),
        .step  (step),
        .value (cnt_full),
        .wrap  (full_wrap)
    );

    roll_flag_fsm u_mod_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (inc_stb),
        .wrap   (mod_wrap),
        .clr    (w1c_mod60),
        .live   (mod60_roll_live),
        .sticky (mod60_wrap_irq)
    );

    roll_flag_fsm u_full_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (inc_stb),
        .wrap   (full_wrap),
        .clr    (w1c_full),
        .live   (full_roll_live),
        .sticky (full_wrap_irq)
    );
endmodule

// File: rtl/mod60_tracker_chk.sv
module mod60_tracker_chk #(
    parameter int MOD    = 60,
    parameter int FULL_W = 48
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inc_stb,
    input logic                   w1c_mod60,
    input logic                   w1c_full,
    input logic [$clog2(MOD)-1:0] cnt_mod60,
    input logic [FULL_W-1:0]      cnt_full,
    input logic                   mod60_roll_live,
    input logic                   full_roll_live,
    input logic                   mod60_wrap_irq,
    input logic                   full_wrap_irq
);
    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_mod60) < MOD); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_stb |=> $stable(cnt_mod60) && $stable(cnt_full)); // R4
    AST_LIVE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_stb |=> $stable(mod60_roll_live) && $stable(full_roll_live)); // R10
    AST_MOD_LIVE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_stb |=> mod60_roll_live == (cnt_mod60 < $past(cnt_mod60))); // R5
    AST_FULL_LIVE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_stb |=> full_roll_live == (cnt_full < $past(cnt_full))); // R8
    AST_MOD_SET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod60_roll_live) |-> mod60_wrap_irq); // R5
    AST_MOD_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        mod60_wrap_irq && !w1c_mod60 |=> mod60_wrap_irq); // R7
    AST_MOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_mod60 && !inc_stb |=> !mod60_wrap_irq); // R6
    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_full && !inc_stb |=> !full_wrap_irq); // R6
endmodule

bind mod60_tracker mod60_tracker_chk #(.MOD(MOD), .FULL_W(FIELD_W*N_FIELDS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .inc_stb         (inc_stb),
    .w1c_mod60       (w1c_mod60),
    .w1c_full        (w1c_full),
    .cnt_mod60       (cnt_mod60),
    .cnt_full        (cnt_full),
    .mod60_roll_live (mod60_roll_live),
    .full_roll_live  (full_roll_live),
    .mod60_wrap_irq  (mod60_wrap_irq),
    .full_wrap_irq   (full_wrap_irq)
);

// File: tb/tb_mod60_tracker.sv
module tb_mod60_tracker;
    localparam int MOD      = 60;
    localparam int TRIM_W   = 3;
    localparam int FIELD_W  = 4;
    localparam int N_FIELDS = 3;
    localparam int FULL_W   = FIELD_W * N_FIELDS;
    localparam int FULL_MOD = 1 << FULL_W;
    localparam int MOD_W    = $clog2(MOD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inc_stb = 1'b0;
    logic [TRIM_W-1:0] trim_amt = '0;
    logic w1c_mod60 = 1'b0;
    logic w1c_full = 1'b0;
    logic [MOD_W-1:0] cnt_mod60;
    logic [FULL_W-1:0] cnt_full;
    logic mod60_roll_live, full_roll_live, mod60_wrap_irq, full_wrap_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string phase = "R9 reset";

    int m_mod = 0;
    int m_full = 0;
    bit m_live_m = 0, m_live_f = 0, m_irq_m = 0, m_irq_f = 0;
    int full_wraps = 0;

    always #5 clk = ~clk;

    mod60_tracker #(.MOD(MOD), .TRIM_W(TRIM_W), .FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) dut (
        .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .trim_amt(trim_amt),
        .w1c_mod60(w1c_mod60), .w1c_full(w1c_full),
        .cnt_mod60(cnt_mod60), .cnt_full(cnt_full),
        .mod60_roll_live(mod60_roll_live), .full_roll_live(full_roll_live),
        .mod60_wrap_irq(mod60_wrap_irq), .full_wrap_irq(full_wrap_irq)
    );

    // behavioural reference model
    always @(posedge clk) begin
        int stp, s, f;
        bit mw, fw;
        if (!rst_n) begin
            m_mod = 0; m_full = 0;
            m_live_m = 0; m_live_f = 0; m_irq_m = 0; m_irq_f = 0;
        end else begin
            stp = (trim_amt == 0) ? 1 : int'(trim_amt);
            mw = 0; fw = 0;
            if (inc_stb) begin
                s = m_mod + stp;
                mw = (s >= MOD);
                m_mod = mw ? s - MOD : s;
                f = m_full + stp;
                fw = (f >= FULL_MOD);
                m_full = f % FULL_MOD;
                m_live_m = mw;
                m_live_f = fw;
                if (fw) full_wraps++;
            end
            m_irq_m = mw ? 1'b1 : (w1c_mod60 ? 1'b0 : m_irq_m);
            m_irq_f = fw ? 1'b1 : (w1c_full ? 1'b0 : m_irq_f);
        end
    end

    task automatic check1(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check1("R1 R2 cnt_mod60", int'(cnt_mod60), m_mod);
        check1("R3 cnt_full", int'(cnt_full), m_full);
        check1("R5 R7 R10 mod60_roll_live", int'(mod60_roll_live), int'(m_live_m));
        check1("R5 R6 mod60_wrap_irq", int'(mod60_wrap_irq), int'(m_irq_m));
        check1("R8 R10 full_roll_live", int'(full_roll_live), int'(m_live_f));
        check1("R8 R6 full_wrap_irq", int'(full_wrap_irq), int'(m_irq_f));
    endtask

    task automatic cyc(input bit inc, input int trim, input bit cm, input bit cf);
        @(negedge clk);
        compare_all();
        inc_stb   = inc;
        trim_amt  = TRIM_W'(trim);
        w1c_mod60 = cm;
        w1c_full  = cf;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;

        phase = "R1 R5 R7 plain";
        for (int i = 0; i < 130; i++) cyc(1, 0, 0, 0);

        phase = "R4 R10 R6 idle clears";
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 5, 0, 0);

        phase = "R2 R6 trimmed";
        for (int i = 0; i < 240; i++) cyc(1, i % 8, (i % 3) == 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

        phase = "R2 R6 w1c on wrap";
        for (int i = 0; i < 120; i++) cyc((i % 4) != 3, 7, (i % 5) == 1, 0);

        phase = "R3 R8 full wrap";
        for (int i = 0; i < 1400; i++) cyc(1, 7 - (i % 2), (i % 7) == 0, (i % 11) == 0);
        phase = "R8 late clear";
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 1);
        cyc(0, 0, 0, 0);
        cyc(1, 1, 0, 0);
        cyc(0, 0, 0, 0);

        if (full_wraps < 2) begin
            failures++;
            $display("FAIL R8 scenario coverage actual=%0d expected>=2 full wraps", full_wraps);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule